// File: doc/BRIEF.md
# Disk Controller Status Word and Interrupt Unit

This block holds the two 18-bit status words of a controller that serves up to eight disk drives. Word A carries the control field (unit select, function, two interrupt enables, go) above a set of sticky address and write-lock error flags, a done flag and an error summary bit. Word B carries one attention flag per drive above a set of sticky transfer-error flags and three flags describing the selected drive. Other logic in the controller reports events on pulse inputs. This block merges those events into the words, applies the clear-status and control-load commands, and raises the interrupt request.

Every clock cycle is one status update. The flags that describe the selected drive are dropped and rebuilt from the live state of that drive. The drive's state arrives on per-drive input vectors: attached, write protected, active, active with a seek or recalibrate, and the stored cylinder. The error summary bit draws on both words. The block produces two registered outputs from the updated words: an interrupt request gated by a done/error enable and an attention enable, and an I/O status summary line.

Top module: `dkst_status_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `stat_a`, `stat_b`, `irq` and `io_summary` are all 0 after that edge.
- R2: Event input bits of A at positions 8..4 and 1, and of B at positions 17..10 and 8..2, are ORed into the word and stay set until a clear removes them (attention bits 17..10 and A bits 8..5 are cleared only by reset). B event bit 9 sets unsafe for one update only. Event bits of A at positions 17..9, 3, 2, 0 and of B at positions 1 and 0 have no effect.
- R3: When `ctl_wr` is high, A bits 17..9 take `ctl_data[17:9]` (unit at 17..15, function at 14..12, done/error interrupt enable at 11, attention interrupt enable at 10, go at 9). The other bits of A are unaffected.
- R4: A bit 3 equals the write-protect input of the drive selected by A bits 17..15 after the update.
- R5: If the selected drive is not attached, or its number is not below NUM_DRIVES, B bits 9 and 0 are set.
- R6: If the selected drive is attached, active and doing a seek, B bits 1 and 0 are set. Otherwise B bit 1 is clear.
- R7: A bit 2 is set only when the selected drive is attached, not active, and its cylinder is at least CYL_LIMIT (203 by default).
- R8: A bit 0 is set exactly when any of A bits 8..4 and 2 or any of B bits 9..2 is set.
- R9: `clr_stat` clears A bits 4 and 1 and B bits 8..2. It leaves A bits 8..5 and the attention bits untouched. Event bits presented in the same cycle still get set.
- R10: `irq` is high exactly when (A bit 1 or A bit 0) and A bit 11 are set, or when any of B bits 17..10 and A bit 10 are set.
- R11: `io_summary` is high exactly when A bit 1 or A bit 0 is set, or any of B bits 17..10 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load the control field of word A |
| ctl_data | input | 18 | Control field source, bits 17..9 used |
| clr_stat | input | 1 | Clear-status command |
| ev_a | input | 18 | Event bits to OR into word A |
| ev_b | input | 18 | Event bits to OR into word B |
| drv_attached | input | NUM_DRIVES | Drive has a medium attached |
| drv_wprot | input | NUM_DRIVES | Drive is write protected |
| drv_active | input | NUM_DRIVES | Drive has an operation in progress |
| drv_seek | input | NUM_DRIVES | Operation in progress is a seek or recalibrate |
| drv_cyl | input | NUM_DRIVES*CYL_W | Stored cylinder of each drive, drive n at slice n |
| stat_a | output | 18 | Status word A |
| stat_b | output | 18 | Status word B |
| irq | output | 1 | Interrupt request |
| io_summary | output | 1 | I/O status summary line |

## Verification
Both words, `irq` and `io_summary` are registered from the same next-state value. Every result is therefore due at the first rising edge after the inputs are presented, including the selected-drive flags and the summary line. The bench changes inputs just after a falling edge and compares all outputs at the following falling edge, one full update later. Pulsed inputs are then removed, and the next comparison shows whether the effect stuck or lasted a single update.

// File: rtl/dkst_pkg.sv
package dkst_pkg;

    localparam int WORD_W = 18;
    localparam int UNIT_W = 3;
    localparam int FUNC_W = 3;
    localparam int MAX_DRIVES = 8;

    typedef logic [WORD_W-1:0] word_t;

    // Word A field positions
    localparam int A_UNIT_LSB  = 15;
    localparam int A_FUNC_LSB  = 12;
    localparam int A_IE_DONE   = 11;
    localparam int A_IE_ATTN   = 10;
    localparam int A_GO        = 9;
    localparam int A_WLK_ERR   = 8;
    localparam int A_NX_CYL    = 7;
    localparam int A_NX_SURF   = 6;
    localparam int A_NX_SECT   = 5;
    localparam int A_HDR_MISS  = 4;
    localparam int A_SEL_WLK   = 3;
    localparam int A_SEL_SKINC = 2;
    localparam int A_DONE      = 1;
    localparam int A_ERR       = 0;

    // Word B field positions
    localparam int B_ATTN_MSB  = 17;
    localparam int B_ATTN_LSB  = 10;
    localparam int B_UNSAFE    = 9;
    localparam int B_PROG      = 8;
    localparam int B_EOP       = 7;
    localparam int B_TIMING    = 6;
    localparam int B_FORMAT    = 5;
    localparam int B_WCHK      = 4;
    localparam int B_WPAR      = 3;
    localparam int B_LPAR      = 2;
    localparam int B_SEEKING   = 1;
    localparam int B_NRDY      = 0;

    // Group masks for word A
    localparam word_t A_CTL_MASK   = 18'h3FE00;  // 17..9
    localparam word_t A_EVENT_MASK = 18'h001F2;  // 8..4, 1
    localparam word_t A_DYN_MASK   = 18'h0000D;  // 3, 2 and summary 0
    localparam word_t A_ERRSRC     = 18'h001F4;  // 8..4, 2
    localparam word_t A_CLR_MASK   = 18'h00012;  // 4, 1

    // Group masks for word B
    localparam word_t B_EVENT_MASK = 18'h3FFFC;  // 17..2
    localparam word_t B_DYN_MASK   = 18'h00203;  // 9, 1, 0
    localparam word_t B_ERRSRC     = 18'h003FC;  // 9..2
    localparam word_t B_CLR_MASK   = 18'h001FC;  // 8..2
    localparam word_t B_ATTN_MASK  = 18'h3FC00;  // 17..10

    // Snapshot of one drive as seen by the status logic
    typedef struct packed {
        logic attached;
        logic wprot;
        logic active;
        logic seek;
        logic cyl_over;
    } drv_view_t;

    localparam drv_view_t DRV_ABSENT = '{attached: 1'b0, wprot: 1'b0,
                                         active: 1'b0, seek: 1'b0,
                                         cyl_over: 1'b0};

    function automatic logic [UNIT_W-1:0] unit_of(input word_t a);
        return a[A_UNIT_LSB +: UNIT_W];
    endfunction

    function automatic word_t bit_of(input int pos);
        word_t w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/dkst_stage.sv
// First half of an update: clear-status, control load, removal of the
// rebuilt bits and merging of the event pulses.
module dkst_stage
    import dkst_pkg::*;
(
    input  word_t cur_a,
    input  word_t cur_b,
    input  logic  ctl_wr,
    input  word_t ctl_data,
    input  logic  clr_stat,
    input  word_t ev_a,
    input  word_t ev_b,
    output word_t base_a,
    output word_t base_b
);

    word_t a_clr, b_clr, a_ctl;

    always_comb begin
        a_clr = clr_stat ? (cur_a & ~A_CLR_MASK) : cur_a;
        b_clr = clr_stat ? (cur_b & ~B_CLR_MASK) : cur_b;

        if (ctl_wr)
            a_ctl = (a_clr & ~A_CTL_MASK) | (ctl_data & A_CTL_MASK);
        else
            a_ctl = a_clr;

        base_a = (a_ctl & ~A_DYN_MASK) | (ev_a & A_EVENT_MASK);
        base_b = (b_clr & ~B_DYN_MASK) | (ev_b & B_EVENT_MASK);
    end

endmodule

// File: rtl/dkst_unit_mux.sv
// Builds a view of every drive and picks the one named by the unit field.
module dkst_unit_mux
    import dkst_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int CYL_W      = 8,
    parameter int CYL_LIMIT  = 203
) (
    input  logic [NUM_DRIVES-1:0]       drv_attached,
    input  logic [NUM_DRIVES-1:0]       drv_wprot,
    input  logic [NUM_DRIVES-1:0]       drv_active,
    input  logic [NUM_DRIVES-1:0]       drv_seek,
    input  logic [NUM_DRIVES*CYL_W-1:0] drv_cyl,
    input  logic [UNIT_W-1:0]           unit_sel,
    output drv_view_t                   sel_view
);

    drv_view_t views [NUM_DRIVES];

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        logic over;
        assign over = int'(drv_cyl[g*CYL_W +: CYL_W]) >= CYL_LIMIT;
        assign views[g] = '{attached: drv_attached[g],
                            wprot:    drv_wprot[g],
                            active:   drv_active[g],
                            seek:     drv_seek[g],
                            cyl_over: over};
    end

    // A unit number with no drive behind it reads as a detached drive.
    always_comb begin
        sel_view = DRV_ABSENT;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            if (unit_sel == UNIT_W'(i))
                sel_view = views[i];
        end
    end

endmodule

// File: rtl/dkst_dyn.sv
// Second half of an update: rebuilt selected-drive flags and error summary.
module dkst_dyn
    import dkst_pkg::*;
(
    input  word_t     base_a,
    input  word_t     base_b,
    input  drv_view_t sel_view,
    output word_t     next_a,
    output word_t     next_b
);

    word_t a_dyn, b_dyn;
    logic  any_err;

    always_comb begin
        a_dyn = base_a;
        b_dyn = base_b;

        if (sel_view.wprot)
            a_dyn[A_SEL_WLK] = 1'b1;

        if (!sel_view.attached) begin
            b_dyn[B_UNSAFE] = 1'b1;
            b_dyn[B_NRDY]   = 1'b1;
        end else if (sel_view.active) begin
            if (sel_view.seek) begin
                b_dyn[B_SEEKING] = 1'b1;
                b_dyn[B_NRDY]    = 1'b1;
            end
        end else if (sel_view.cyl_over) begin
            a_dyn[A_SEL_SKINC] = 1'b1;
        end

        any_err = (|(a_dyn & A_ERRSRC)) | (|(b_dyn & B_ERRSRC));

        next_a        = a_dyn;
        next_a[A_ERR] = any_err;
        next_b        = b_dyn;
    end

endmodule

// File: rtl/dkst_irq_gen.sv
// Interrupt request and I/O summary formed from an updated pair of words.
module dkst_irq_gen
    import dkst_pkg::*;
(
    input  logic       done,
    input  logic       err,
    input  logic       ie_done,
    input  logic       ie_attn,
    input  logic [7:0] attn,
    output logic       irq_req,
    output logic       summary
);

    logic fin, any_attn;

    always_comb begin
        fin      = done | err;
        any_attn = |attn;
        irq_req  = (fin & ie_done) | (any_attn & ie_attn);
        summary  = fin | any_attn;
    end

endmodule

// File: rtl/dkst_status_core.sv
module dkst_status_core
    import dkst_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int CYL_W      = 8,
    parameter int CYL_LIMIT  = 203
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctl_wr,
    input  logic [WORD_W-1:0]           ctl_data,
    input  logic                        clr_stat,
    input  logic [WORD_W-1:0]           ev_a,
    input  logic [WORD_W-1:0]           ev_b,
    input  logic [NUM_DRIVES-1:0]       drv_attached,
    input  logic [NUM_DRIVES-1:0]       drv_wprot,
    input  logic [NUM_DRIVES-1:0]       drv_active,
    input  logic [NUM_DRIVES-1:0]       drv_seek,
    input  logic [NUM_DRIVES*CYL_W-1:0] drv_cyl,
    output logic [WORD_W-1:0]           stat_a,
    output logic [WORD_W-1:0]           stat_b,
    output logic                        irq,
    output logic                        io_summary
);

    word_t     reg_a, reg_b;
    word_t     base_a, base_b;
    word_t     next_a, next_b;
    drv_view_t sel_view;
    logic      irq_next, sum_next;
    logic      irq_q, sum_q;

    dkst_stage i_stage (
        .cur_a    (reg_a),
        .cur_b    (reg_b),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .clr_stat (clr_stat),
        .ev_a     (ev_a),
        .ev_b     (ev_b),
        .base_a   (base_a),
        .base_b   (base_b)
    );

    // The unit that is selected after this update supplies the drive flags.
    dkst_unit_mux #(
        .NUM_DRIVES (NUM_DRIVES),
        .CYL_W      (CYL_W),
        .CYL_LIMIT  (CYL_LIMIT)
    ) i_unit_mux (
        .drv_attached (drv_attached),
        .drv_wprot    (drv_wprot),
        .drv_active   (drv_active),
        .drv_seek     (drv_seek),
        .drv_cyl      (drv_cyl),
        .unit_sel     (unit_of(base_a)),
        .sel_view     (sel_view)
    );

    dkst_dyn i_dyn (
        .base_a   (base_a),
        .base_b   (base_b),
        .sel_view (sel_view),
        .next_a   (next_a),
        .next_b   (next_b)
    );

    dkst_irq_gen i_irq_gen (
        .done    (next_a[A_DONE]),
        .err     (next_a[A_ERR]),
        .ie_done (next_a[A_IE_DONE]),
        .ie_attn (next_a[A_IE_ATTN]),
        .attn    (next_b[B_ATTN_MSB:B_ATTN_LSB]),
        .irq_req (irq_next),
        .summary (sum_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
            irq_q <= 1'b0;
            sum_q <= 1'b0;
        end else begin
            reg_a <= next_a;
            reg_b <= next_b;
            irq_q <= irq_next;
            sum_q <= sum_next;
        end
    end

    assign stat_a     = reg_a;
    assign stat_b     = reg_b;
    assign irq        = irq_q;
    assign io_summary = sum_q;

endmodule

// File: rtl/dkst_status_chk.sv
module dkst_status_chk
    import dkst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic [WORD_W-1:0] ctl_data,
    input logic              clr_stat,
    input logic [WORD_W-1:0] ev_a,
    input logic [WORD_W-1:0] ev_b,
    input logic [WORD_W-1:0] stat_a,
    input logic [WORD_W-1:0] stat_b,
    input logic              irq,
    input logic              io_summary
);

    localparam word_t A_HELD = 18'h001E0;  // 8..5

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_a == '0 && stat_b == '0 && !irq && !io_summary)); // R1

    AST_ATTN_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_b & $past(stat_b & B_ATTN_MASK)) == $past(stat_b & B_ATTN_MASK))); // R2

    AST_ADDR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_a & $past(stat_a & A_HELD)) == $past(stat_a & A_HELD))); // R2

    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_wr) |-> ((stat_a & A_CTL_MASK) == ($past(ctl_data) & A_CTL_MASK))); // R3

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        stat_a[A_ERR] == ((|(stat_a & A_ERRSRC)) || (|(stat_b & B_ERRSRC)))); // R8

    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (rst)
        $past(clr_stat && ev_a == '0 && ev_b == '0) |->
            ((stat_a & A_CLR_MASK) == '0 && (stat_b & B_CLR_MASK) == '0)); // R9

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        irq == (((stat_a[A_DONE] || stat_a[A_ERR]) && stat_a[A_IE_DONE]) ||
                ((|(stat_b & B_ATTN_MASK)) && stat_a[A_IE_ATTN]))); // R10

    AST_IO_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        io_summary == (stat_a[A_DONE] || stat_a[A_ERR] || (|(stat_b & B_ATTN_MASK)))); // R11

endmodule

bind dkst_status_core dkst_status_chk i_chk (.*);

// File: tb/test_dkst_status_core.sv
`timescale 1ns/100ps
module test_dkst_status_core;

    localparam int ND  = 6;
    localparam int CW  = 8;
    localparam int LIM = 203;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_wr = 1'b0;
    logic [17:0]   ctl_data = '0;
    logic          clr_stat = 1'b0;
    logic [17:0]   ev_a = '0;
    logic [17:0]   ev_b = '0;
    logic [ND-1:0] d_att = '1;
    logic [ND-1:0] d_wp = '0;
    logic [ND-1:0] d_act = '0;
    logic [ND-1:0] d_sk = '0;
    logic [ND*CW-1:0] d_cyl = '0;
    logic [17:0]   stat_a, stat_b;
    logic          irq, io_summary;

    logic [17:0] m_a = '0, m_b = '0;
    logic        m_i = 1'b0, m_s = 1'b0;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dkst_status_core #(.NUM_DRIVES(ND), .CYL_W(CW), .CYL_LIMIT(LIM)) i_dkst_status_core (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .clr_stat(clr_stat), .ev_a(ev_a), .ev_b(ev_b),
        .drv_attached(d_att), .drv_wprot(d_wp), .drv_active(d_act),
        .drv_seek(d_sk), .drv_cyl(d_cyl),
        .stat_a(stat_a), .stat_b(stat_b), .irq(irq), .io_summary(io_summary)
    );

    // Expected next words, built from the requirement text.
    task automatic model(output logic [17:0] na, output logic [17:0] nb,
                         output logic ni, output logic ns);
        logic [17:0] a, b;
        int u;
        logic att, wp, act, sk, ovr;
        a = m_a;
        b = m_b;
        if (clr_stat) begin                         // R9
            a = a & ~18'h00012;
            b = b & ~18'h001FC;
        end
        if (ctl_wr) a = (a & ~18'h3FE00) | (ctl_data & 18'h3FE00);   // R3
        a = (a & ~18'h0000D) | (ev_a & 18'h001F2);  // R2
        b = (b & ~18'h00203) | (ev_b & 18'h3FFFC);
        u = int'(a[17:15]);
        if (u < ND) begin
            att = d_att[u]; wp = d_wp[u]; act = d_act[u]; sk = d_sk[u];
            ovr = int'(d_cyl[u*CW +: CW]) >= LIM;
        end else begin
            att = 0; wp = 0; act = 0; sk = 0; ovr = 0;
        end
        if (wp) a[3] = 1'b1;                         // R4
        if (!att) begin b[9] = 1'b1; b[0] = 1'b1; end            // R5
        else if (act && sk) begin b[1] = 1'b1; b[0] = 1'b1; end  // R6
        else if (!act && ovr) a[2] = 1'b1;           // R7
        a[0] = (|(a & 18'h001F4)) | (|(b & 18'h003FC));           // R8
        ni = ((a[1] | a[0]) & a[11]) | ((|b[17:10]) & a[10]);     // R10
        ns = a[1] | a[0] | (|b[17:10]);                           // R11
        na = a;
        nb = b;
    endtask

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag,   stat_a & ~18'h0000D, m_a & ~18'h0000D);
        chk(tag,   stat_b & ~18'h00203, m_b & ~18'h00203);
        chk("R4",  {17'b0, stat_a[3]}, {17'b0, m_a[3]});
        chk("R5",  {16'b0, stat_b[9], stat_b[0]}, {16'b0, m_b[9], m_b[0]});
        chk("R6",  {17'b0, stat_b[1]}, {17'b0, m_b[1]});
        chk("R7",  {17'b0, stat_a[2]}, {17'b0, m_a[2]});
        chk("R8",  {17'b0, stat_a[0]}, {17'b0, m_a[0]});
        chk("R10", {17'b0, irq}, {17'b0, m_i});
        chk("R11", {17'b0, io_summary}, {17'b0, m_s});
    endtask

    // Inputs set after a falling edge; result due at the next falling edge.
    task automatic step(input string tag);
        logic [17:0] na, nb;
        logic ni, ns;
        model(na, nb, ni, ns);
        @(negedge clk);
        m_a = na; m_b = nb; m_i = ni; m_s = ns;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m_a = '0; m_b = '0; m_i = 1'b0; m_s = 1'b0;
        compare("R1");
        chk("R1", stat_a, 18'h0);
        chk("R1", stat_b, 18'h0);
        rst = 1'b0;
    endtask

    task automatic load_ctl(input logic [17:0] d);
        ctl_wr = 1'b1;
        ctl_data = d;
        step("R3");
        ctl_wr = 1'b0;
        ctl_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Selected-drive flags for every unit and every drive state.
        for (int u = 0; u < 8; u++) begin
            load_ctl({u[2:0], u[2:0] ^ 3'd5, u[0], 1'b0, 1'b1, 9'h1FF});
            for (int c = 0; c < 32; c++) begin
                for (int j = 0; j < ND; j++) begin
                    if (j == u) begin
                        d_att[j] = c[0]; d_wp[j] = c[1]; d_act[j] = c[2];
                        d_sk[j] = c[3];
                        d_cyl[j*CW +: CW] = c[4] ? (c[2] ? 8'd203 : 8'd255)
                                                 : (c[1] ? 8'd202 : 8'd0);
                    end else begin
                        d_att[j] = ~c[0]; d_wp[j] = ~c[1]; d_act[j] = ~c[2];
                        d_sk[j] = ~c[3];
                        d_cyl[j*CW +: CW] = c[4] ? 8'd10 : 8'd250;
                    end
                end
                step("R7");
            end
        end

        // Event bits one at a time, each pulsed then observed afterwards.
        do_reset();
        d_att = '1; d_wp = '0; d_act = '0; d_sk = '0; d_cyl = '0;
        load_ctl(18'h0);
        for (int i = 0; i < 18; i++) begin
            ev_a = 18'(1) << i;
            step("R2");
            ev_a = '0;
            step("R2");
        end
        for (int i = 0; i < 18; i++) begin
            ev_b = 18'(1) << i;
            step("R2");
            ev_b = '0;
            step("R2");
        end
        clr_stat = 1'b1;
        step("R9");
        clr_stat = 1'b0;
        step("R9");
        ev_a = '1; ev_b = '1;
        step("R2");
        ev_a = 18'h00010; ev_b = 18'h00020;
        clr_stat = 1'b1;
        step("R9");
        ev_a = '0; ev_b = '0; clr_stat = 1'b0;
        step("R9");
        load_ctl('1);
        load_ctl(18'h001FF);

        // Interrupt gating over both enables and each source.
        for (int en = 0; en < 4; en++) begin
            for (int c = 0; c < 8; c++) begin
                do_reset();
                load_ctl({6'b0, en[1:0], 10'b0});
                ev_a = (c[0] ? 18'h00002 : 18'h0) | (c[1] ? 18'h00020 : 18'h0);
                ev_b = c[2] ? 18'h20000 : 18'h0;
                step("R10");
                ev_a = '0; ev_b = '0;
                step("R10");
                clr_stat = 1'b1;
                step("R11");
                clr_stat = 1'b0;
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule